// File: doc/BRIEF.md
# Interrupt Wake-Up Controller

This block collects interrupt requests for a processor core that can be put into clock-gated low-power states. It watches two active-low external request pins, called A and B, and a vector of peripheral request lines. It keeps a sticky pending flag for each source and clears that flag when its own acknowledge input is pulsed. Each external pin has an enable bit and a sense bit. In run mode the sense bit picks falling-edge detection, which goes through a synchronizer, or low-level detection.

When the mode input selects wait or stop, the block drives a wake request to the clock and system logic. This request is pure logic with no flop in its path, so it can assert while the clock is stopped. In these states the external pins are always treated as low-level requests, whatever their sense bit says. Only sources whose enable was set when the low-power state was entered can cause a wake. In stop, peripherals that need a running clock to raise a request are left out. The CAN wake input is counted in both wait and stop.

When the core returns to run, pending flags are kept. An enabled external pin that is still held low records its interrupt, so the request that caused the wake is not lost.

Top module: `irq_wake_ctrl`

## Requirements
- R1: Synchronous active-high reset clears every pending flag, puts the block in run mode (mode_i encoding: 0 = run, 1 = wait, 2 = stop, 3 = stop), and holds wake_o low.
- R2: In run, an enabled external pin with its sense bit at 1 (falling edge) sets its pending flag after a high-to-low change seen through a two-stage synchronizer. A pin that stays low does not set the flag again after it is acknowledged.
- R3: In run, an enabled external pin with its sense bit at 0 (level) sets its pending flag on every cycle that its synchronized level is low.
- R4: An acknowledge bit clears its pending flag. If a set condition is present in the same cycle, the set wins.
- R5: In run, a peripheral pending flag is set on every cycle in which its request and its enable are both 1.
- R6: In wait or stop, an enabled external pin that is low raises wake_o at once, with no clock edge, whatever its sense bit.
- R7: In wait or stop, wake uses the enable bits captured on the cycle the low-power state was entered. Changes to the enable inputs made later have no effect on wake_o.
- R8: In stop (mode 2 or 3), a peripheral whose needs-clock bit is 1 cannot raise wake_o. In wait, the same peripheral can raise wake_o.
- R9: In wait or stop, can_wake_i raises wake_o.
- R10: Pending flags hold their values through wait and stop. On the first run cycle after a low-power state, an external pin that was enabled at entry and whose synchronized level is low sets its pending flag.
- R11: wake_o is low whenever mode_i selects run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Power mode: 0 run, 1 wait, 2/3 stop |
| ext_n_i | input | 2 | External request pins, active low (bit 0 = A, bit 1 = B) |
| ext_edge_i | input | 2 | Sense bit per pin: 1 falling edge, 0 low level (run only) |
| ext_en_i | input | 2 | External pin enables |
| ext_ack_i | input | 2 | External pending acknowledge |
| per_req_i | input | NUM_PERIPH | Peripheral request lines, active high |
| per_en_i | input | NUM_PERIPH | Peripheral enables |
| per_needs_clk_i | input | NUM_PERIPH | 1 = peripheral needs a clock to raise a request |
| per_ack_i | input | NUM_PERIPH | Peripheral pending acknowledge |
| can_wake_i | input | 1 | CAN bus activity wake |
| ext_pend_o | output | 2 | External pending flags |
| per_pend_o | output | NUM_PERIPH | Peripheral pending flags |
| wake_o | output | 1 | Wake request to clock/system logic |

## Verification
The bench builds the block with NUM_PERIPH = 4 and SYNC_STAGES = 2. With these values one peripheral can be marked as needing a clock while the others are not, so a single stop/wait sequence can check both the wake exclusion and the wake permission. The two-stage synchronizer makes the timing of edge and level detection fixed and known, so the reference model can predict the exact cycle in which each pending flag changes. That includes the flag set on the first run cycle after leaving a low-power state.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;

    localparam int NUM_EXT = 2;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_WAIT  = 2'd1,
        PM_STOP  = 2'd2,
        PM_STOP2 = 2'd3
    } pmode_e;

    typedef struct packed {
        logic low_power;
        logic leaving;
        logic stop;
    } lp_state_t;

    function automatic logic is_low_power(input logic [1:0] m);
        return m != PM_RUN;
    endfunction

    function automatic logic is_stop(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/irq_lp_tracker.sv
module irq_lp_tracker
    import irq_wake_pkg::*;
#(
    parameter int NUM_PERIPH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            mode_i,
    input  logic [NUM_EXT-1:0]    ext_en_i,
    input  logic [NUM_PERIPH-1:0] per_en_i,
    output lp_state_t             st_o,
    output logic [NUM_EXT-1:0]    ext_en_eff_o,
    output logic [NUM_PERIPH-1:0] per_en_eff_o,
    output logic [NUM_EXT-1:0]    ext_shadow_o
);
    logic                  lp_q;
    logic                  entering;
    logic [NUM_EXT-1:0]    ext_sh_q;
    logic [NUM_PERIPH-1:0] per_sh_q;

    always_comb begin
        st_o.low_power = is_low_power(mode_i);
        st_o.stop      = is_stop(mode_i);
        st_o.leaving   = !st_o.low_power && lp_q;
        entering       = st_o.low_power && !lp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lp_q     <= 1'b0;
            ext_sh_q <= '0;
            per_sh_q <= '0;
        end else begin
            lp_q <= st_o.low_power;
            if (entering) begin
                ext_sh_q <= ext_en_i;
                per_sh_q <= per_en_i;
            end
        end
    end

    // On the entry cycle the snapshot is not yet loaded: use live enables.
    assign ext_en_eff_o = lp_q ? ext_sh_q : ext_en_i;
    assign per_en_eff_o = lp_q ? per_sh_q : per_en_i;
    assign ext_shadow_o = ext_sh_q;
endmodule

// File: rtl/irq_ext_pin_cell.sv
module irq_ext_pin_cell #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    input  logic edge_i,
    input  logic en_i,
    input  logic shadow_en_i,
    input  logic ack_i,
    input  logic low_power_i,
    input  logic leaving_i,
    output logic pend_o
);
    // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] chain_q;
    logic synced_n, prev_n, fall, set_c;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[SYNC_STAGES-1:0], pin_n_i};
    end

    assign synced_n = chain_q[SYNC_STAGES-1];
    assign prev_n   = chain_q[SYNC_STAGES];
    assign fall     = prev_n && !synced_n;

    always_comb begin
        set_c = 1'b0;
        if (!low_power_i) begin
            set_c = en_i && (edge_i ? fall : !synced_n);
            if (leaving_i && shadow_en_i && !synced_n) set_c = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               pend_o <= 1'b0;
        else if (!low_power_i) pend_o <= (pend_o && !ack_i) || set_c;
    end
endmodule

// File: rtl/irq_per_pend_bank.sv
module irq_per_pend_bank #(
    parameter int NUM_PERIPH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  low_power_i,
    input  logic [NUM_PERIPH-1:0] req_i,
    input  logic [NUM_PERIPH-1:0] en_i,
    input  logic [NUM_PERIPH-1:0] ack_i,
    output logic [NUM_PERIPH-1:0] pend_o
);
    always_ff @(posedge clk) begin
        if (rst)               pend_o <= '0;
        else if (!low_power_i) pend_o <= (pend_o & ~ack_i) | (req_i & en_i);
    end
endmodule

// File: rtl/irq_wake_combiner.sv
module irq_wake_combiner
    import irq_wake_pkg::*;
#(
    parameter int NUM_PERIPH = 8
) (
    input  lp_state_t             st_i,
    input  logic [NUM_EXT-1:0]    ext_n_i,
    input  logic [NUM_EXT-1:0]    ext_en_eff_i,
    input  logic [NUM_PERIPH-1:0] per_req_i,
    input  logic [NUM_PERIPH-1:0] per_en_eff_i,
    input  logic [NUM_PERIPH-1:0] per_needs_clk_i,
    input  logic                  can_wake_i,
    output logic                  wake_o
);
    logic [NUM_PERIPH-1:0] per_allowed;
    logic ext_hit, per_hit;

    always_comb begin
        per_allowed = st_i.stop ? ~per_needs_clk_i : '1;
        ext_hit     = |(ext_en_eff_i & ~ext_n_i);
        per_hit     = |(per_req_i & per_en_eff_i & per_allowed);
        wake_o      = st_i.low_power && (ext_hit || per_hit || can_wake_i);
    end
endmodule

// File: rtl/irq_wake_ctrl.sv
module irq_wake_ctrl
    import irq_wake_pkg::*;
#(
    parameter int NUM_PERIPH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            mode_i,
    input  logic [1:0]            ext_n_i,
    input  logic [1:0]            ext_edge_i,
    input  logic [1:0]            ext_en_i,
    input  logic [1:0]            ext_ack_i,
    input  logic [NUM_PERIPH-1:0] per_req_i,
    input  logic [NUM_PERIPH-1:0] per_en_i,
    input  logic [NUM_PERIPH-1:0] per_needs_clk_i,
    input  logic [NUM_PERIPH-1:0] per_ack_i,
    input  logic                  can_wake_i,
    output logic [1:0]            ext_pend_o,
    output logic [NUM_PERIPH-1:0] per_pend_o,
    output logic                  wake_o
);
    lp_state_t             st;
    logic [NUM_EXT-1:0]    ext_en_eff, ext_shadow;
    logic [NUM_PERIPH-1:0] per_en_eff;

    irq_lp_tracker #(.NUM_PERIPH(NUM_PERIPH)) u_track (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .ext_en_i(ext_en_i), .per_en_i(per_en_i),
        .st_o(st), .ext_en_eff_o(ext_en_eff),
        .per_en_eff_o(per_en_eff), .ext_shadow_o(ext_shadow)
    );

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
        irq_ext_pin_cell #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk(clk), .rst(rst),
            .pin_n_i(ext_n_i[g]), .edge_i(ext_edge_i[g]),
            .en_i(ext_en_i[g]), .shadow_en_i(ext_shadow[g]),
            .ack_i(ext_ack_i[g]),
            .low_power_i(st.low_power), .leaving_i(st.leaving),
            .pend_o(ext_pend_o[g])
        );
    end

    irq_per_pend_bank #(.NUM_PERIPH(NUM_PERIPH)) u_per (
        .clk(clk), .rst(rst), .low_power_i(st.low_power),
        .req_i(per_req_i), .en_i(per_en_i), .ack_i(per_ack_i),
        .pend_o(per_pend_o)
    );

    irq_wake_combiner #(.NUM_PERIPH(NUM_PERIPH)) u_wake (
        .st_i(st), .ext_n_i(ext_n_i), .ext_en_eff_i(ext_en_eff),
        .per_req_i(per_req_i), .per_en_eff_i(per_en_eff),
        .per_needs_clk_i(per_needs_clk_i), .can_wake_i(can_wake_i),
        .wake_o(wake_o)
    );
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
module irq_wake_ctrl_chk #(
    parameter int NUM_PERIPH = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            mode_i,
    input logic [1:0]            ext_n_i,
    input logic [1:0]            ext_ack_i,
    input logic [NUM_PERIPH-1:0] per_req_i,
    input logic [NUM_PERIPH-1:0] per_needs_clk_i,
    input logic                  can_wake_i,
    input logic [1:0]            ext_pend_o,
    input logic [NUM_PERIPH-1:0] per_pend_o,
    input logic                  wake_o
);
    AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd0) |-> !wake_o); // R11

    AST_PEND_HOLD_LP: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 2'd0) |=> ($stable(ext_pend_o) && $stable(per_pend_o))); // R10

    AST_CAN_WAKES: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 2'd0 && can_wake_i) |-> wake_o); // R9

    AST_STOP_WAKE_SRC: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1] && wake_o) |->
            (can_wake_i || (ext_n_i != 2'b11) || |(per_req_i & ~per_needs_clk_i))); // R8

    for (genvar g = 0; g < 2; g++) begin : g_ext
        AST_EXT_CLR_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
            $fell(ext_pend_o[g]) |-> ($past(ext_ack_i[g]) || $past(rst))); // R4
        AST_EXT_SET_IN_RUN: assert property (@(posedge clk) disable iff (rst)
            $rose(ext_pend_o[g]) |-> ($past(mode_i) == 2'd0)); // R10
    end
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) chk_i (.*);

// File: tb/irq_wake_ctrl_tb_top.sv
module irq_wake_ctrl_tb_top;
    localparam int  NP       = 4;
    localparam time CLK_PER  = 10;
    localparam int  WD_LIMIT = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0, ext_n = 2'b11, ext_edge = 2'b00, ext_en = 2'b00, ext_ack = 2'b00;
    logic [NP-1:0] per_req = '0, per_en = '0, per_nclk = '0, per_ack = '0;
    logic          can = 1'b0;
    logic [1:0]    ext_pend;
    logic [NP-1:0] per_pend;
    logic          wake;

    int n_checks = 0, n_fail = 0;
    string phase = "R1";

    always #(CLK_PER/2) clk = ~clk;

    irq_wake_ctrl #(.NUM_PERIPH(NP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .mode_i(mode), .ext_n_i(ext_n),
        .ext_edge_i(ext_edge), .ext_en_i(ext_en), .ext_ack_i(ext_ack),
        .per_req_i(per_req), .per_en_i(per_en), .per_needs_clk_i(per_nclk),
        .per_ack_i(per_ack), .can_wake_i(can),
        .ext_pend_o(ext_pend), .per_pend_o(per_pend), .wake_o(wake)
    );

    // ---------------- behavioural reference model ----------------
    int m_ep[2], m_pp[NP], m_sh_e[2], m_sh_p[NP];
    int m_lp;
    int hist[2][$];   // per pin: [0] = newest sampled level

    always @(posedge clk) begin
        if (rst) begin
            m_lp = 0;
            for (int i = 0; i < 2; i++) begin
                m_ep[i] = 0; m_sh_e[i] = 0;
                hist[i] = '{1, 1, 1};
            end
            for (int i = 0; i < NP; i++) begin m_pp[i] = 0; m_sh_p[i] = 0; end
        end else begin
            int lpm, leaving;
            lpm = (mode != 2'd0);
            leaving = !lpm && m_lp;
            if (!lpm) begin
                for (int i = 0; i < 2; i++) begin
                    int lowq, fall, s;
                    lowq = (hist[i][1] == 0);
                    fall = (hist[i][1] == 0) && (hist[i][2] == 1);
                    s = (ext_en[i] && (ext_edge[i] ? fall : lowq)) || (leaving && m_sh_e[i] && lowq);
                    m_ep[i] = (m_ep[i] && !ext_ack[i]) || s;
                end
                for (int i = 0; i < NP; i++)
                    m_pp[i] = (m_pp[i] && !per_ack[i]) || (per_req[i] && per_en[i]);
            end
            if (lpm && !m_lp) begin
                for (int i = 0; i < 2; i++) m_sh_e[i] = ext_en[i];
                for (int i = 0; i < NP; i++) m_sh_p[i] = per_en[i];
            end
            m_lp = lpm;
            for (int i = 0; i < 2; i++) begin
                hist[i].push_front(int'(ext_n[i]));
                void'(hist[i].pop_back());
            end
        end
    end

    function automatic int exp_wake();
        int lpm, stp, w;
        lpm = (mode != 2'd0);
        stp = mode[1];
        w = can;
        for (int i = 0; i < 2; i++)
            if ((m_lp ? m_sh_e[i] : ext_en[i]) && !ext_n[i]) w = 1;
        for (int i = 0; i < NP; i++)
            if (per_req[i] && (m_lp ? m_sh_p[i] : per_en[i]) && !(stp && per_nclk[i])) w = 1;
        return lpm && w;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            int ee, pe;
            ee = 0; pe = 0;
            for (int i = 0; i < 2; i++) ee |= (m_ep[i] << i);
            for (int i = 0; i < NP; i++) pe |= (m_pp[i] << i);
            check(phase, "ext_pend", int'(ext_pend), ee);
            check(phase, "per_pend", int'(per_pend), pe);
            check(phase, "wake", int'(wake), exp_wake());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        #1;
        check("R1", "reset ext_pend", int'(ext_pend), 0);
        check("R1", "reset per_pend", int'(per_pend), 0);
        check("R1", "reset wake", int'(wake), 0);

        // R2: falling edge on pin A
        phase = "R2";
        ext_en = 2'b01; ext_edge = 2'b01;
        tick(2);
        ext_n[0] = 1'b0;
        tick(4);
        check("R2", "edge sets pend A", int'(ext_pend[0]), 1);
        ext_ack[0] = 1'b1; tick(1); ext_ack[0] = 1'b0;
        tick(3);
        check("R2", "held low no re-set", int'(ext_pend[0]), 0);
        ext_n[0] = 1'b1; tick(3);

        // R3/R4: level on pin B, set wins over ack
        phase = "R3";
        ext_en = 2'b10; ext_edge = 2'b00;
        ext_n[1] = 1'b0;
        tick(4);
        check("R3", "level sets pend B", int'(ext_pend[1]), 1);
        phase = "R4";
        ext_ack[1] = 1'b1;
        tick(3);
        check("R4", "set wins over ack", int'(ext_pend[1]), 1);
        ext_n[1] = 1'b1;
        tick(4);
        check("R4", "ack clears", int'(ext_pend[1]), 0);
        ext_ack[1] = 1'b0; tick(1);

        // R5: peripheral pending
        phase = "R5";
        per_en = 4'b0110; per_req = 4'b0010;
        tick(1);
        check("R5", "periph pend", int'(per_pend), 2);
        per_req = 4'b0100; tick(1); per_req = '0;
        per_ack = 4'b0010; tick(1); per_ack = '0;
        check("R5", "periph pend kept bit2", int'(per_pend), 4);

        // R6/R10: stop with edge-configured pin A
        phase = "R6";
        ext_en = 2'b01; ext_edge = 2'b11; ext_n = 2'b11;
        mode = 2'd2;
        tick(3);
        check("R6", "no wake idle stop", int'(wake), 0);
        ext_n[0] = 1'b0; #1;
        check("R6", "level wake no clock", int'(wake), 1);
        tick(3);
        check("R10", "pend held in stop", int'(ext_pend), 0);
        check("R10", "periph pend held in stop", int'(per_pend), 4);

        // R7: enable set after entry has no effect
        phase = "R7";
        ext_n[0] = 1'b1; ext_en = 2'b11; ext_n[1] = 1'b0; #1;
        check("R7", "late enable ignored", int'(wake), 0);
        tick(2);
        ext_n[1] = 1'b1; ext_n[0] = 1'b0; ext_en = 2'b01;
        tick(3);

        // R10: exit with pin A still low
        phase = "R10";
        mode = 2'd0;
        tick(2);
        check("R10", "exit records pin A", int'(ext_pend[0]), 1);
        check("R10", "periph pend after wake", int'(per_pend), 4);
        ext_n[0] = 1'b1; ext_ack = 2'b11; per_ack = '1; tick(1);
        ext_ack = 2'b00; per_ack = '0; tick(3);

        // R8: clock-needing peripheral
        phase = "R8";
        ext_en = 2'b00; per_en = 4'b0001; per_nclk = 4'b0001;
        mode = 2'd2; tick(2);
        per_req = 4'b0001; #1;
        check("R8", "clk periph blocked in stop", int'(wake), 0);
        mode = 2'd3; #1;
        check("R8", "clk periph blocked mode 3", int'(wake), 0);
        mode = 2'd1; #1;
        check("R8", "clk periph wakes in wait", int'(wake), 1);
        tick(2);
        per_req = '0; mode = 2'd2; tick(2);

        // R9/R11: CAN wake
        phase = "R9";
        can = 1'b1; #1;
        check("R9", "can wakes in stop", int'(wake), 1);
        tick(1);
        phase = "R11";
        mode = 2'd0; #1;
        check("R11", "no wake in run", int'(wake), 0);
        can = 1'b0; per_ack = '1; tick(1); per_ack = '0;
        tick(3);

        summary();
    end
endmodule